// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one SDRAM read or write burst. A controller pulses `start_i` with the starting column and the burst configuration. From the next cycle the block presents the first column on `col_o` with `valid_o` high. Each cycle in which `adv_i` is high moves it to the next column of the burst. `last_o` marks the final beat of a fixed-length burst.

Two orderings are supported inside the wrap boundary. Sequential counting increments the low bits and wraps within the burst length. Interleaved ordering XORs the low bits of the start column with the beat number. Full-page bursts cover all 512 columns, wrap modulo 512 and run until `term_i` ends them. A full-page burst with interleaved ordering is not a legal setting. Such a start is refused and reported on `cfg_err_o`.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high and in the first cycle after reset is released, `valid_o`, `last_o` and `cfg_err_o` are low.
- R2: `bl_sel_i` encodes the burst length as 0→1, 1→2, 2→4, 3→8 and 4→full page (512). `wrap_sel_i` selects 0 = sequential and 1 = interleaved. In the cycle after an accepted start, `valid_o` is high and `col_o` equals the start column.
- R3: In sequential mode, beat i has the start column's upper bits, and its low log2(BL) bits are (start low bits + i) mod BL.
- R4: In interleaved mode, beat i has the start column's upper bits, and its low log2(BL) bits are start low bits XOR i.
- R5: The burst moves one beat only in a cycle with `adv_i` high. Otherwise `col_o` and `valid_o` hold.
- R6: For fixed lengths, `last_o` is high exactly on beat BL-1. An advance on that beat ends the burst, and `valid_o` is low in the next cycle.
- R7: A full-page burst runs through the columns modulo 512, never raises `last_o`, and stays valid until it is terminated.
- R8: `term_i` ends any burst, and `valid_o` is low in the next cycle. `start_i` takes priority over `term_i` and `adv_i` in the same cycle.
- R9: A start with full page plus interleaved ordering, or with `bl_sel_i` 5 to 7, is refused. No burst runs, any running burst stops, and `cfg_err_o` is high from the next cycle until the next accepted start.
- R10: The length and ordering inputs are sampled only at an accepted start. Changing them during a burst has no effect on its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst with the inputs below |
| start_col_i | input | 9 | First column of the burst |
| bl_sel_i | input | 3 | Burst length code |
| wrap_sel_i | input | 1 | 0 sequential, 1 interleaved |
| adv_i | input | 1 | Advance to the next beat |
| term_i | input | 1 | Terminate the current burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A burst is in progress |
| last_o | output | 1 | Current beat is the final one |
| cfg_err_o | output | 1 | Last start was refused |

## Verification
The embedded properties take for granted that `start_i`, `adv_i` and `term_i` are clean single-cycle levels sampled at the rising edge. They also assume that `adv_i` or `term_i` raised outside a burst does no harm. The stimulus keeps to these conditions in two ways. It changes every input only on the falling edge. It holds the configuration inputs steady through each start cycle, and moves them only during a burst in the test that shows they are ignored there.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int COL_W    = 9;
    localparam int BL_SEL_W = 3;

    typedef logic [COL_W-1:0] col_t;

    typedef enum logic [BL_SEL_W-1:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd4
    } bl_code_e;

    typedef enum logic {
        WRAP_SEQ = 1'b0,
        WRAP_ILV = 1'b1
    } wrap_e;

    typedef struct packed {
        col_t  mask;   // low bits that move within the burst
        logic  page;   // full-page burst, no last beat
        wrap_e wrap;
    } burst_cfg_t;

    // Wrap mask for a length code: BL-1, or all ones for a page.
    function automatic col_t len_mask(input logic [BL_SEL_W-1:0] code);
        col_t m;
        case (code)
            BL_ONE:   m = '0;
            BL_TWO:   m = col_t'(1);
            BL_FOUR:  m = col_t'(3);
            BL_EIGHT: m = col_t'(7);
            default:  m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bcg_cfg_decode.sv
module bcg_cfg_decode
    import burst_col_pkg::*;
(
    input  logic [BL_SEL_W-1:0] bl_sel_i,
    input  logic                wrap_sel_i,
    output burst_cfg_t          cfg_o,
    output logic                reject_o
);

    always_comb begin
        cfg_o.mask = len_mask(bl_sel_i);
        cfg_o.page = (bl_sel_i == BL_PAGE);
        cfg_o.wrap = wrap_sel_i ? WRAP_ILV : WRAP_SEQ;
        reject_o   = (bl_sel_i > BL_PAGE) ||
                     ((bl_sel_i == BL_PAGE) && wrap_sel_i);
    end

endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr
    import burst_col_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic       stop_i,
    input  logic       step_i,
    input  burst_cfg_t cfg_i,
    output col_t       beat_o,
    output logic       active_o,
    output logic       last_o
);

    col_t beat_q;
    logic active_q;

    assign last_o   = active_q && !cfg_i.page && (beat_q == cfg_i.mask);
    assign beat_o   = beat_q;
    assign active_o = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            beat_q   <= '0;
        end else if (load_i) begin
            active_q <= 1'b1;
            beat_q   <= '0;
        end else if (stop_i) begin
            active_q <= 1'b0;
        end else if (active_q && step_i) begin
            if (last_o) active_q <= 1'b0;
            else        beat_q   <= beat_q + col_t'(1);
        end
    end

    // R6
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (last_o && step_i && !load_i && !stop_i) |=> !active_o);

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
    import burst_col_pkg::*;
(
    input  col_t       base_i,
    input  col_t       beat_i,
    input  burst_cfg_t cfg_i,
    output col_t       col_o
);

    col_t seq_sum;
    assign seq_sum = base_i + beat_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!cfg_i.mask[b])
                col_o[b] = base_i[b];
            else if (cfg_i.wrap == WRAP_ILV)
                col_o[b] = base_i[b] ^ beat_i[b];
            else
                col_o[b] = seq_sum[b];
        end
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [COL_W-1:0]    start_col_i,
    input  logic [BL_SEL_W-1:0] bl_sel_i,
    input  logic                wrap_sel_i,
    input  logic                adv_i,
    input  logic                term_i,
    output logic [COL_W-1:0]    col_o,
    output logic                valid_o,
    output logic                last_o,
    output logic                cfg_err_o
);

    burst_cfg_t cfg_new, cfg_q;
    logic       reject;
    col_t       base_q, beat;
    logic       err_q, accept, stop;

    bcg_cfg_decode u_dec (
        .bl_sel_i  (bl_sel_i),
        .wrap_sel_i(wrap_sel_i),
        .cfg_o     (cfg_new),
        .reject_o  (reject)
    );

    assign accept = start_i && !reject;
    assign stop   = term_i || (start_i && reject);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            base_q <= '0;
            err_q  <= 1'b0;
        end else if (start_i) begin
            err_q <= reject;
            if (!reject) begin
                cfg_q  <= cfg_new;
                base_q <= start_col_i;
            end
        end
    end

    bcg_beat_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (accept),
        .stop_i  (stop),
        .step_i  (adv_i),
        .cfg_i   (cfg_q),
        .beat_o  (beat),
        .active_o(valid_o),
        .last_o  (last_o)
    );

    bcg_addr_map u_map (
        .base_i(base_q),
        .beat_i(beat),
        .cfg_i (cfg_q),
        .col_o (col_o)
    );

    assign cfg_err_o = err_q;

    // R2
    start_col_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !reject) |=> (valid_o && col_o == $past(start_col_i)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !adv_i && !start_i && !term_i) |=> (valid_o && $stable(col_o)));

    // R7
    page_runs_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && cfg_q.page && !start_i && !term_i) |=> (valid_o && !last_o));

    // R8
    term_chk: assert property (@(posedge clk) disable iff (rst)
        (term_i && !start_i) |=> !valid_o);

    // R9
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && reject) |=> (cfg_err_o && !valid_o));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !start_i) |=> $stable(cfg_q));

endmodule

// File: tb/test_burst_col_gen.sv
`timescale 1ns/100ps
module test_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] bl_sel_i = '0;
    logic       wrap_sel_i = 1'b0;
    logic       adv_i = 1'b0;
    logic       term_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o, last_o, cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_gen i_burst_col_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .bl_sel_i(bl_sel_i), .wrap_sel_i(wrap_sel_i), .adv_i(adv_i),
        .term_i(term_i), .col_o(col_o), .valid_o(valid_o),
        .last_o(last_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(int s, int bl, bit ilv, int i);
        int base, low;
        if (bl == 512) return (s + i) % 512;
        base = s - (s % bl);
        low  = s % bl;
        return ilv ? base + (low ^ i) : base + ((low + i) % bl);
    endfunction

    function automatic int code_len(int code);
        return (code == 4) ? 512 : (1 << code);
    endfunction

    // Called at a falling edge; returns at the falling edge after the start.
    task automatic do_start(int s, int code, bit w);
        start_i = 1'b1; start_col_i = 9'(s); bl_sel_i = 3'(code); wrap_sel_i = w;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic step();
        adv_i = 1'b1;
        @(posedge clk); @(negedge clk);
        adv_i = 1'b0;
    endtask

    task automatic run_burst(string req, int s, int code, bit w);
        int bl = code_len(code);
        do_start(s, code, w);
        check("R2 valid", int'(valid_o), 1);
        for (int i = 0; i < bl; i++) begin
            check(req, int'(col_o), exp_col(s, bl, w, i));
            check("R6 last", int'(last_o), int'(i == bl - 1));
            step();
        end
        check("R6 end", int'(valid_o), 0);
    endtask

    task automatic t_reset();
        check("R1 valid", int'(valid_o), 0);
        check("R1 last", int'(last_o), 0);
        check("R1 err", int'(cfg_err_o), 0);
    endtask

    task automatic t_seq();
        run_burst("R3 bl1", 9'h007, 0, 1'b0);
        run_burst("R3 bl2", 9'h013, 1, 1'b0);
        run_burst("R3 bl4", 9'h1FE, 2, 1'b0);
        run_burst("R3 bl8", 9'h00B, 3, 1'b0);
    endtask

    task automatic t_ilv();
        run_burst("R4 bl8", 9'h005, 3, 1'b1);
        run_burst("R4 bl4", 9'h01E, 2, 1'b1);
        run_burst("R4 bl2", 9'h101, 1, 1'b1);
        run_burst("R4 bl1", 9'h0AA, 0, 1'b1);
    endtask

    task automatic t_stall();
        do_start(9'h00A, 2, 1'b0);
        step();
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            check("R5 hold col", int'(col_o), 9'h00B);
            check("R5 hold valid", int'(valid_o), 1);
        end
        step();
        check("R5 moved", int'(col_o), 9'h008);
        term_i = 1'b1; @(posedge clk); @(negedge clk); term_i = 1'b0;
    endtask

    task automatic t_page();
        do_start(508, 4, 1'b0);
        check("R7 err", int'(cfg_err_o), 0);
        for (int i = 0; i < 600; i++) begin
            check("R7 col", int'(col_o), exp_col(508, 512, 1'b0, i));
            check("R7 last", int'(last_o), 0);
            check("R7 valid", int'(valid_o), 1);
            step();
        end
        term_i = 1'b1; @(posedge clk); @(negedge clk); term_i = 1'b0;
        check("R8 page term", int'(valid_o), 0);
    endtask

    task automatic t_term();
        do_start(9'h040, 3, 1'b0);
        step(); step();
        check("R8 pre", int'(col_o), 9'h042);
        term_i = 1'b1; adv_i = 1'b1;
        @(posedge clk); @(negedge clk);
        term_i = 1'b0; adv_i = 1'b0;
        check("R8 term", int'(valid_o), 0);
        // start and term together: start wins
        term_i = 1'b1;
        do_start(9'h0C3, 2, 1'b1);
        term_i = 1'b0;
        check("R8 start wins", int'(valid_o), 1);
        check("R8 start col", int'(col_o), 9'h0C3);
        step();
        check("R8 next", int'(col_o), 9'h0C2);
        term_i = 1'b1; @(posedge clk); @(negedge clk); term_i = 1'b0;
    endtask

    task automatic t_reject();
        do_start(9'h010, 3, 1'b0);
        do_start(9'h020, 4, 1'b1);
        check("R9 err", int'(cfg_err_o), 1);
        check("R9 stopped", int'(valid_o), 0);
        @(posedge clk); @(negedge clk);
        check("R9 err held", int'(cfg_err_o), 1);
        do_start(9'h020, 6, 1'b0);
        check("R9 code6 err", int'(cfg_err_o), 1);
        check("R9 code6 idle", int'(valid_o), 0);
        do_start(9'h021, 1, 1'b0);
        check("R9 cleared", int'(cfg_err_o), 0);
        check("R9 new burst", int'(col_o), 9'h021);
        step(); step();
        check("R9 done", int'(valid_o), 0);
    endtask

    task automatic t_cfg_hold();
        do_start(9'h003, 3, 1'b0);
        bl_sel_i = 3'd0; wrap_sel_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            check("R10 col", int'(col_o), exp_col(3, 8, 1'b0, i));
            check("R10 last", int'(last_o), int'(i == 7));
            step();
        end
        check("R10 end", int'(valid_o), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", int'(valid_o), 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        t_reset();
        t_seq();
        t_ilv();
        t_stall();
        t_page();
        t_term();
        t_reject();
        t_cfg_hold();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule